// File: doc/BRIEF.md
# Sound Register Bus Width Adapter

This block sits between a CPU load/store port and a sound peripheral whose register file only accepts 16-bit accesses. The CPU issues byte, halfword or word accesses at any I/O offset. The adapter claims only the sound window. Inside that window it turns each access into zero, one or two 16-bit register transactions.

A word access becomes two halfword transactions on back-to-back cycles: the lower half at the given offset, then the upper half at the offset plus 2. A byte read fetches the aligned halfword and picks one lane. A byte write lands only when its offset is even. The CPU sees a busy flag for the whole of an access and a one-cycle ready pulse that carries the read result.

The register port is strobe based. The register file must present `reg_rdata` combinationally during the cycle in which `reg_rd` is high.

Top module: `snd_bus_adapter`

## Requirements
- R1: The window is decoded on the start offset only. Offsets from 0x1C00 up to but not including 0x2000 are forwarded. Any other access raises no strobe, still completes, and returns read data 0.
- R2: A word write (size code 2'b10) issues two write strobes on consecutive cycles. The first carries wdata[15:0] at offset A. The second carries wdata[31:16] at A+2.
- R3: A word read issues two read strobes, at A and then at A+2. It returns the second halfword in bits 31:16 and the first in bits 15:0.
- R4: A halfword access (size code 2'b01) issues one strobe at A. A write carries wdata[15:0]. A read returns the halfword zero-extended to 32 bits.
- R5: A byte read (size code 2'b00) issues one read strobe at A with bit 0 cleared. It returns bits 15:8 of the halfword when A[0]=1 and bits 7:0 when A[0]=0, zero-extended to 32 bits.
- R6: A byte write to an even offset issues one write strobe whose data is the byte zero-extended: {8'h00, wdata[7:0]}.
- R7: A byte write to an odd offset raises no strobe, leaves the register file unchanged, and still completes with a ready pulse.
- R8: A request is accepted only while `cpu_busy` is low. Counting from the accepting edge, `cpu_ready` is a one-cycle pulse in cycle 1 for an access that is not forwarded, in cycle 2 for a single transaction and in cycle 3 for a split one. `cpu_busy` is high from cycle 1 through the ready cycle. A request raised while busy is ignored.
- R9: During and after reset, `cpu_busy`, `cpu_ready`, `reg_wr`, `reg_rd` and `cpu_rdata` are all 0.
- R10: The size code 2'b11 is never forwarded. It completes like an access outside the window.
- R11: A read strobe and a write strobe are never high in the same cycle. No strobe is high in a ready cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | Access request, sampled while not busy |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_size | input | 2 | 00 byte, 01 halfword, 10 word, 11 reserved |
| cpu_addr | input | ADDR_W | I/O offset of the access |
| cpu_wdata | input | 2*REG_W | Write data |
| cpu_busy | output | 1 | Access in progress |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 2*REG_W | Read result, valid with cpu_ready |
| reg_addr | output | ADDR_W | Register port offset |
| reg_wdata | output | REG_W | Register port write data |
| reg_wr | output | 1 | Register write strobe |
| reg_rd | output | 1 | Register read strobe |
| reg_rdata | input | REG_W | Register read data, same cycle as reg_rd |

## Verification
The bench probes both edges of the window (0x1BFE, 0x1C00, 0x1FFE and 0x2000). An off-by-one comparison would either leak a strobe to a neighbouring peripheral or lose a valid sound register. Odd and even byte writes are checked against later reads. A design that forwarded the odd one would clobber the low lane, and one that did not zero-extend would leave stale upper bits. Split word accesses are checked for order and half placement, since swapped halves or a missing +2 corrupt the value. Latency and a request held during busy are also checked, because a second acceptance would duplicate strobes.

// File: rtl/snd_adapt_pkg.sv
// Shared types for the sound register bus width adapter.
// Assumes: size codes are fixed by the CPU bus (00 byte, 01 half, 10 word).
package snd_adapt_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } acc_size_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_LO   = 2'b01,
        ST_HI   = 2'b10,
        ST_DONE = 2'b11
    } seq_state_t;

    // Decoded intent of one CPU access
    typedef struct packed {
        logic fwd;      // reaches the register port at all
        logic split;    // needs a second (upper) halfword transaction
        logic is_wr;    // write access
        logic is_byte;  // byte access
        logic lane_hi;  // byte access selects bits 15:8
    } acc_plan_t;

endpackage

// File: rtl/snd_win_decode.sv
// Window and size decoder.
// Turns a raw CPU access into a plan: whether it is forwarded, whether it is
// split into two halves, and which byte lane it uses. It also gives the base
// register offset (byte accesses aligned down to even).
// Assumes: the window test looks at the start offset only.
module snd_win_decode
    import snd_adapt_pkg::*;
#(
    parameter int                ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] WIN_BASE = 16'h1C00,
    parameter logic [ADDR_W-1:0] WIN_END  = 16'h2000
) (
    input  logic              we,
    input  logic [1:0]        size,
    input  logic [ADDR_W-1:0] addr,
    output acc_plan_t         plan,
    output logic [ADDR_W-1:0] base_addr
);

    logic      in_win;
    logic      odd_byte_wr;
    acc_size_t sz;

    // Classify the access against the window and the size code
    always_comb begin
        sz          = acc_size_t'(size);
        in_win      = (addr >= WIN_BASE) && (addr < WIN_END);
        odd_byte_wr = (sz == SZ_BYTE) && we && addr[0];

        plan.fwd     = in_win && (sz != SZ_RSVD) && !odd_byte_wr;
        plan.split   = (sz == SZ_WORD);
        plan.is_wr   = we;
        plan.is_byte = (sz == SZ_BYTE);
        plan.lane_hi = addr[0];

        if (sz == SZ_BYTE) begin
            base_addr = {addr[ADDR_W-1:1], 1'b0};
        end else begin
            base_addr = addr;
        end
    end

endmodule

// File: rtl/snd_half_seq.sv
// Transaction sequencer.
// Walks IDLE -> LO [-> HI] -> DONE for forwarded accesses and IDLE -> DONE
// for dropped ones. DONE lasts one cycle and marks completion.
// Assumes: 'split' is stable from the cycle after 'start'.
module snd_half_seq
    import snd_adapt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       fwd,
    input  logic       split,
    output seq_state_t state
);

    seq_state_t nxt;

    // Next-state selection
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (start) nxt = fwd ? ST_LO : ST_DONE;
            ST_LO:   nxt = split ? ST_HI : ST_DONE;
            ST_HI:   nxt = ST_DONE;
            ST_DONE: nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    // State register with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

endmodule

// File: rtl/snd_lane_pack.sv
// Lane steering for both directions.
// Write side: chooses the halfword sent in each phase (upper half in the
// second phase, a zero-extended byte for byte writes). Read side: captures
// each returned halfword and assembles the 32-bit result.
// Assumes: read data is valid in the same cycle as the read strobe.
module snd_lane_pack
    import snd_adapt_pkg::*;
#(
    parameter int REG_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               cap_lo,
    input  logic               cap_hi,
    input  logic               second,
    input  acc_plan_t          plan,
    input  logic [2*REG_W-1:0] wdata,
    input  logic [REG_W-1:0]   reg_rdata,
    output logic [REG_W-1:0]   reg_wdata,
    output logic [2*REG_W-1:0] cpu_rdata
);

    localparam int CPU_W  = 2 * REG_W;
    localparam int BYTE_W = REG_W / 2;

    logic [REG_W-1:0] lo_q;
    logic [REG_W-1:0] hi_q;

    // Pick the halfword driven on the register write bus
    always_comb begin
        if (second) begin
            reg_wdata = wdata[CPU_W-1:REG_W];
        end else if (plan.is_byte) begin
            reg_wdata = {{(REG_W-BYTE_W){1'b0}}, wdata[BYTE_W-1:0]};
        end else begin
            reg_wdata = wdata[REG_W-1:0];
        end
    end

    // Capture returned halfwords, cleared at the start of each access
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            if (cap_lo) lo_q <= reg_rdata;
            if (cap_hi) hi_q <= reg_rdata;
        end
    end

    // Assemble the CPU-side read result from the captured halves
    always_comb begin
        if (!plan.fwd || plan.is_wr) begin
            cpu_rdata = '0;
        end else if (plan.is_byte) begin
            cpu_rdata = {{(CPU_W-BYTE_W){1'b0}},
                         plan.lane_hi ? lo_q[REG_W-1:BYTE_W] : lo_q[BYTE_W-1:0]};
        end else if (plan.split) begin
            cpu_rdata = {hi_q, lo_q};
        end else begin
            cpu_rdata = {{(CPU_W-REG_W){1'b0}}, lo_q};
        end
    end

endmodule

// File: rtl/snd_bus_adapter.sv
// Sound register bus width adapter (top).
// Accepts one CPU access at a time while idle and latches its plan, offset
// and data. It then drives zero, one or two 16-bit register transactions and
// pulses ready when the access is complete.
// Assumes: the register file answers reads combinationally and accepts a
// write in the strobe cycle.
module snd_bus_adapter
    import snd_adapt_pkg::*;
#(
    parameter int                ADDR_W   = 16,
    parameter int                REG_W    = 16,
    parameter logic [ADDR_W-1:0] WIN_BASE = 16'h1C00,
    parameter logic [ADDR_W-1:0] WIN_END  = 16'h2000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cpu_req,
    input  logic                 cpu_we,
    input  logic [1:0]           cpu_size,
    input  logic [ADDR_W-1:0]    cpu_addr,
    input  logic [2*REG_W-1:0]   cpu_wdata,
    output logic                 cpu_busy,
    output logic                 cpu_ready,
    output logic [2*REG_W-1:0]   cpu_rdata,
    output logic [ADDR_W-1:0]    reg_addr,
    output logic [REG_W-1:0]     reg_wdata,
    output logic                 reg_wr,
    output logic                 reg_rd,
    input  logic [REG_W-1:0]     reg_rdata
);

    localparam int                CPU_W     = 2 * REG_W;
    localparam logic [ADDR_W-1:0] HALF_STEP = ADDR_W'(REG_W / 8);

    seq_state_t        state;
    acc_plan_t         plan_now;
    acc_plan_t         plan_q;
    logic [ADDR_W-1:0] base_now;
    logic [ADDR_W-1:0] addr_q;
    logic [CPU_W-1:0]  wdata_q;
    logic              accept;
    logic              issue;
    logic              second;

    snd_win_decode #(
        .ADDR_W   (ADDR_W),
        .WIN_BASE (WIN_BASE),
        .WIN_END  (WIN_END)
    ) u_dec (
        .we        (cpu_we),
        .size      (cpu_size),
        .addr      (cpu_addr),
        .plan      (plan_now),
        .base_addr (base_now)
    );

    // Acceptance: only an idle adapter takes a request
    always_comb begin
        accept = cpu_req && (state == ST_IDLE);
    end

    // Latch the access description at acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            plan_q  <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            plan_q  <= plan_now;
            addr_q  <= base_now;
            wdata_q <= cpu_wdata;
        end
    end

    snd_half_seq u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .start (accept),
        .fwd   (plan_now.fwd),
        .split (plan_q.split),
        .state (state)
    );

    // Register-port strobes and offset for the current phase
    always_comb begin
        issue     = (state == ST_LO) || (state == ST_HI);
        second    = (state == ST_HI);
        reg_wr    = issue && plan_q.is_wr;
        reg_rd    = issue && !plan_q.is_wr;
        reg_addr  = second ? (addr_q + HALF_STEP) : addr_q;
        cpu_busy  = (state != ST_IDLE);
        cpu_ready = (state == ST_DONE);
    end

    snd_lane_pack #(
        .REG_W (REG_W)
    ) u_lane (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (accept),
        .cap_lo    (reg_rd && !second),
        .cap_hi    (reg_rd && second),
        .second    (second),
        .plan      (plan_q),
        .wdata     (wdata_q),
        .reg_rdata (reg_rdata),
        .reg_wdata (reg_wdata),
        .cpu_rdata (cpu_rdata)
    );

endmodule

// File: rtl/snd_bus_adapter_chk.sv
// Protocol checker for the sound register bus width adapter, bound to the top.
// Assumes: reset is asserted from time zero.
module snd_bus_adapter_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_req,
    input logic              cpu_busy,
    input logic              cpu_ready,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_wr,
    input logic              reg_rd
);

    // R8
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && !cpu_busy) |=> cpu_busy);

    // R8
    ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |=> !cpu_ready);

    // R8
    ready_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |-> cpu_busy);

    // R11
    strobe_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_rd));

    // R11
    strobe_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr || reg_rd) |-> (cpu_busy && !cpu_ready));

    // R2
    second_half_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((reg_wr || reg_rd) && $past(reg_wr || reg_rd))
            |-> (reg_addr == $past(reg_addr) + ADDR_W'(2)));

    // R3
    split_same_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((reg_wr || reg_rd) && $past(reg_wr || reg_rd))
            |-> (reg_wr == $past(reg_wr)));

endmodule

bind snd_bus_adapter snd_bus_adapter_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_req   (cpu_req),
    .cpu_busy  (cpu_busy),
    .cpu_ready (cpu_ready),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd)
);

// File: tb/snd_bus_adapter_test.sv
`timescale 1ns/1ps
module snd_bus_adapter_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0;
    logic        cpu_we = 1'b0;
    logic [1:0]  cpu_size = 2'b00;
    logic [15:0] cpu_addr = '0;
    logic [31:0] cpu_wdata = '0;
    logic        cpu_busy, cpu_ready;
    logic [31:0] cpu_rdata;
    logic [15:0] reg_addr, reg_wdata, reg_rdata;
    logic        reg_wr, reg_rd;

    int nchk = 0;
    int nfail = 0;

    logic [15:0] mem [512];
    logic [15:0] log_addr [4];
    logic [15:0] log_data [4];
    logic        log_wr   [4];

    always #2 clk = ~clk;

    snd_bus_adapter uut (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_size(cpu_size), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_busy(cpu_busy), .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_rdata(reg_rdata)
    );

    // Register file model: combinational read, write at the strobe edge
    assign reg_rdata = mem[reg_addr[9:1]];
    always @(posedge clk) if (reg_wr) mem[reg_addr[9:1]] <= reg_wdata;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One CPU access. poke keeps a different request raised while busy.
    task automatic do_acc(input logic we, input logic [1:0] sz, input logic [15:0] a,
                          input logic [31:0] wd, input bit poke,
                          output logic [31:0] rd, output int ns, output int lat);
        ns = 0; lat = 0; rd = '0;
        cpu_req = 1'b1; cpu_we = we; cpu_size = sz; cpu_addr = a; cpu_wdata = wd;
        @(negedge clk);
        if (poke) begin
            cpu_we = 1'b1; cpu_size = 2'b01; cpu_addr = a + 16'd2; cpu_wdata = 32'h5555;
        end else begin
            cpu_req = 1'b0;
        end
        for (int k = 1; k <= 20; k++) begin
            if (k == 2) cpu_req = 1'b0;
            if (reg_wr || reg_rd) begin
                if (ns < 4) begin
                    log_addr[ns] = reg_addr; log_data[ns] = reg_wdata; log_wr[ns] = reg_wr;
                end
                ns++;
            end
            if (cpu_ready) begin
                rd = cpu_rdata; lat = k;
                break;
            end
            @(negedge clk);
        end
        cpu_req = 1'b0;
        @(negedge clk);
    endtask

    typedef struct packed {
        logic        we;
        logic [1:0]  sz;
        logic [15:0] addr;
        logic [31:0] wd;
        logic [31:0] exp;
        logic [1:0]  nstb;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 2'b10, 16'h1C10, 32'hA1B2C3D4, 32'h0,        2'd2, 8'd2},
        '{1'b0, 2'b10, 16'h1C10, 32'h0,        32'hA1B2C3D4, 2'd2, 8'd3},
        '{1'b0, 2'b01, 16'h1C12, 32'h0,        32'h0000A1B2, 2'd1, 8'd4},
        '{1'b0, 2'b00, 16'h1C11, 32'h0,        32'h000000C3, 2'd1, 8'd5},
        '{1'b0, 2'b00, 16'h1C10, 32'h0,        32'h000000D4, 2'd1, 8'd5},
        '{1'b1, 2'b00, 16'h1C20, 32'h9876545A, 32'h0,        2'd1, 8'd6},
        '{1'b0, 2'b01, 16'h1C20, 32'h0,        32'h0000005A, 2'd1, 8'd6},
        '{1'b1, 2'b00, 16'h1C21, 32'h000000FF, 32'h0,        2'd0, 8'd7},
        '{1'b0, 2'b01, 16'h1C20, 32'h0,        32'h0000005A, 2'd1, 8'd7},
        '{1'b1, 2'b01, 16'h1C30, 32'h1234BEEF, 32'h0,        2'd1, 8'd4},
        '{1'b0, 2'b10, 16'h1C30, 32'h0,        32'h0000BEEF, 2'd2, 8'd3},
        '{1'b1, 2'b01, 16'h1BFE, 32'h00001234, 32'h0,        2'd0, 8'd1},
        '{1'b0, 2'b10, 16'h2000, 32'h0,        32'h0,        2'd0, 8'd1},
        '{1'b1, 2'b01, 16'h1C00, 32'h00007777, 32'h0,        2'd1, 8'd1},
        '{1'b0, 2'b01, 16'h1C00, 32'h0,        32'h00007777, 2'd1, 8'd1},
        '{1'b1, 2'b01, 16'h1FFE, 32'h00004321, 32'h0,        2'd1, 8'd1},
        '{1'b0, 2'b01, 16'h1FFE, 32'h0,        32'h00004321, 2'd1, 8'd1},
        '{1'b1, 2'b11, 16'h1C00, 32'h0000AAAA, 32'h0,        2'd0, 8'd10}
    };

    bit done = 1'b0;

    initial begin
        #(4 * 20000);
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        int ns, lat;
        for (int i = 0; i < 512; i++) mem[i] = '0;
        repeat (4) @(negedge clk);
        // R9 reset state
        chk("R9 busy", {31'b0, cpu_busy}, 32'h0);
        chk("R9 ready", {31'b0, cpu_ready}, 32'h0);
        chk("R9 strobes", {30'b0, reg_wr, reg_rd}, 32'h0);
        chk("R9 rdata", cpu_rdata, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // Vector table walk: data and strobe count for every requirement class
        for (int i = 0; i < NV; i++) begin
            do_acc(VECS[i].we, VECS[i].sz, VECS[i].addr, VECS[i].wd, 1'b0, rd, ns, lat);
            chk($sformatf("R%0d data v%0d", VECS[i].req, i), rd, VECS[i].exp);
            chk($sformatf("R%0d strobes v%0d", VECS[i].req, i), 32'(ns), 32'(VECS[i].nstb));
        end
        // R10 reserved size left the register at 0x1C00 untouched
        do_acc(1'b0, 2'b01, 16'h1C00, 32'h0, 1'b0, rd, ns, lat);
        chk("R10 no write", rd, 32'h00007777);

        // R2 order and halves of a split write, latency 3
        do_acc(1'b1, 2'b10, 16'h1C40, 32'h11112222, 1'b0, rd, ns, lat);
        chk("R2 first addr", 32'(log_addr[0]), 32'h1C40);
        chk("R2 first data", 32'(log_data[0]), 32'h2222);
        chk("R2 second addr", 32'(log_addr[1]), 32'h1C42);
        chk("R2 second data", 32'(log_data[1]), 32'h1111);
        chk("R8 word latency", 32'(lat), 32'd3);
        // R3 read order
        do_acc(1'b0, 2'b10, 16'h1C40, 32'h0, 1'b0, rd, ns, lat);
        chk("R3 first addr", 32'(log_addr[0]), 32'h1C40);
        chk("R3 second addr", 32'(log_addr[1]), 32'h1C42);
        chk("R3 read dir", {31'b0, log_wr[1]}, 32'h0);
        // R5 aligned byte read strobe
        do_acc(1'b0, 2'b00, 16'h1C43, 32'h0, 1'b0, rd, ns, lat);
        chk("R5 aligned addr", 32'(log_addr[0]), 32'h1C42);
        chk("R5 upper byte", rd, 32'h00000011);
        chk("R8 single latency", 32'(lat), 32'd2);
        // R6 zero-extended byte write data on the port
        do_acc(1'b1, 2'b00, 16'h1C44, 32'hFFFFFF3C, 1'b0, rd, ns, lat);
        chk("R6 port data", 32'(log_data[0]), 32'h003C);
        // R7 odd byte write completes in one cycle
        do_acc(1'b1, 2'b00, 16'h1C45, 32'h77, 1'b0, rd, ns, lat);
        chk("R7 latency", 32'(lat), 32'd1);
        do_acc(1'b0, 2'b01, 16'h1C44, 32'h0, 1'b0, rd, ns, lat);
        chk("R7 unchanged", rd, 32'h0000003C);
        // R1 out-of-window latency
        do_acc(1'b0, 2'b01, 16'h0100, 32'h0, 1'b0, rd, ns, lat);
        chk("R1 latency", 32'(lat), 32'd1);
        // R8 request held during busy is ignored
        do_acc(1'b1, 2'b01, 16'h1C50, 32'hAAAA, 1'b1, rd, ns, lat);
        chk("R8 busy strobes", 32'(ns), 32'd1);
        do_acc(1'b0, 2'b01, 16'h1C52, 32'h0, 1'b0, rd, ns, lat);
        chk("R8 busy ignored", rd, 32'h0);
        do_acc(1'b0, 2'b01, 16'h1C50, 32'h0, 1'b0, rd, ns, lat);
        chk("R4 half written", rd, 32'h0000AAAA);
        // R11 idle after completion: no strobes, not busy
        chk("R11 idle strobes", {30'b0, reg_wr, reg_rd}, 32'h0);
        chk("R8 idle busy", {31'b0, cpu_busy}, 32'h0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule